// File: doc/BRIEF.md
# PHY Management Access Controller

This block lets a host reach the registers of an external Ethernet PHY through the two-wire management interface (MDC clock, bidirectional MDIO data). The host writes a single 32-bit command word. The word holds the operation, the PHY address, the register number and, for a write, the data. The controller then sends one complete management frame. On a read, it shifts the PHY's reply into the low half of the same word.

Completion is reported in that same word. The host polls the word until the done flag (bit 28) or the fault flag (bit 30) is set. On a read, the low 16 bits then hold the returned value. That value is not to be trusted when the fault flag is set.

MDC is produced by dividing the system clock by a parameter. It runs only while a frame is in flight. The MDIO pad is modelled as three separate signals: an output, an output enable and an input.

Top module: `mdio_access_ctrl`

## Requirements
- R1: Command word fields are as follows. The register number is in bits 20:16, the PHY address in bits 25:21 and the operation in bits 27:26 (01 is write, 10 is read). Write data is in bits 15:0. Bits 27:0 of the status word read back the accepted operation, PHY address and register number. For a write, bits 15:0 read back the written data.
- R2: Accepting a command clears the done flag (bit 28) and the fault flag (bit 30). Bits 31 and 29 always read zero.
- R3: A command written while a frame is in progress is ignored. The status word does not change, and no further frame follows the current one.
- R4: MDC toggles only during a frame, with a period of MDC_DIV system clocks. It rests low when idle. Each frame takes exactly 64 MDC periods.
- R5: The frame is sent MSB first in this order:
  - 32 ones,
  - start bits 01,
  - the 2-bit operation,
  - the 5-bit PHY address,
  - the 5-bit register number,
  - 2 turnaround bits, which a write drives as 10,
  - 16 data bits.
- R6: MDIO output changes only at MDC falling edges. MDIO input is sampled at MDC rising edges.
- R7: On a read, the output enable is deasserted for both turnaround bits and all 16 data bits. The data bits are captured MSB first into bits 15:0.
- R8: On a read, if MDIO is sampled high during the second turnaround bit, the fault flag (bit 30) is set when the access completes.
- R9: The done flag sets in the same clock in which the final MDC falling edge ends the frame. The output enable is low whenever the controller is idle.
- R10: A command whose operation field is 00 or 11 sends no frame. It completes on the next clock edge with both the done and fault flags set and bits 15:0 cleared.
- R11: After reset the status word is zero, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | One-cycle strobe that writes cmd_wdata as a new command |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Status word: command fields, done (28), fault (30), data (15:0) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume a few things about the inputs:
- cmd_wr is a clean single-cycle strobe, synchronous to clk.
- mdio_i is driven by a PHY that changes it only at MDC falling edges, so it is stable at every sampling edge.
- MDC_DIV is even and at least 2.

The bench's PHY model respects these assumptions. It updates its reply bit only on the falling edge of MDC and otherwise holds MDIO high, as a pull-up would. Command strobes are applied between clock edges. Random commands use only the two legal operation codes. The illegal codes and the write issued while busy are reached only through directed cases.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int SLOT_TA0  = 46;
  localparam int SLOT_TA1  = 47;
  localparam int SLOT_D0   = 48;
  localparam int DATA_W    = 16;
  localparam int FIELD_W   = 5;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic [1:0]         op;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regad;
    logic [DATA_W-1:0]  data;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(DIV / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign rise_stb = run && (cnt == HALF_M1);
  assign fall_stb = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_stb ? '0 : cnt + 1'b1;
      if (rise_stb)      mdc <= 1'b1;
      else if (fall_stb) mdc <= 1'b0;
    end
  end

  // R4: clock parks low once the frame stops
  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 op_rd,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 ta_err
);
  localparam int SW = $clog2(FRAME_LEN);
  localparam logic [SW-1:0] S_LAST = SW'(FRAME_LEN - 1);
  localparam logic [SW-1:0] S_TA0  = SW'(SLOT_TA0);
  localparam logic [SW-1:0] S_TA1  = SW'(SLOT_TA1);
  localparam logic [SW-1:0] S_D0   = SW'(SLOT_D0);

  logic [SW-1:0]        slot;
  logic [SW-1:0]        next_slot;
  logic [FRAME_LEN-1:0] tx_sr;
  logic                 is_rd;
  logic                 last_slot;

  assign next_slot = slot + 1'b1;
  assign last_slot = (slot == S_LAST);
  assign done      = busy && fall_stb && last_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      slot    <= '0;
      tx_sr   <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
      ta_err  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        slot    <= '0;
        tx_sr   <= frame;
        is_rd   <= op_rd;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
        rd_data <= '0;
        ta_err  <= 1'b0;
      end
    end else begin
      if (rise_stb && is_rd) begin
        if (slot == S_TA1) ta_err <= mdio_i;
        if (slot >= S_D0)  rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        if (last_slot) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          slot    <= next_slot;
          tx_sr   <= {tx_sr[FRAME_LEN-2:0], 1'b0};
          mdio_o  <= tx_sr[FRAME_LEN-2];
          mdio_oe <= !(is_rd && (next_slot >= S_TA0));
        end
      end
    end
  end

  // independent count of divider rising strobes within the frame
  logic [SW:0] rise_seen;
  always_ff @(posedge clk) begin
    if (rst)                  rise_seen <= '0;
    else if (start && !busy)  rise_seen <= '0;
    else if (busy && rise_stb) rise_seen <= rise_seen + 1'b1;
  end

  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (rise_seen == (SW+1)'(FRAME_LEN)));

  assert_oe_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_wr,
  input  logic [31:0]          cmd_wdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [DATA_W-1:0]    rd_data,
  input  logic                 ta_err,
  output logic                 start,
  output logic                 op_rd,
  output logic [FRAME_LEN-1:0] frame,
  output logic [31:0]          cmd_rdata
);
  mgmt_cmd_t c_in;
  mgmt_cmd_t cur;
  logic      ready;
  logic      fault;
  logic      accept;
  logic      op_ok;
  logic      op_wr;

  assign c_in  = mgmt_cmd_t'(cmd_wdata[27:0]);
  assign op_wr = (c_in.op == OP_WR);
  assign op_rd = (c_in.op == OP_RD);
  assign op_ok = op_wr || op_rd;

  assign accept = cmd_wr && !busy;
  assign start  = accept && op_ok;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, c_in.op, c_in.phy, c_in.regad,
                  op_rd ? 2'b11 : 2'b10,
                  op_rd ? {DATA_W{1'b1}} : c_in.data};

  wire unused_hi = &{1'b0, cmd_wdata[31:28]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      ready <= 1'b0;
      fault <= 1'b0;
    end else if (accept) begin
      cur.op    <= c_in.op;
      cur.phy   <= c_in.phy;
      cur.regad <= c_in.regad;
      cur.data  <= op_wr ? c_in.data : '0;
      ready     <= !op_ok;
      fault     <= !op_ok;
    end else if (done) begin
      ready <= 1'b1;
      if (cur.op == OP_RD) begin
        cur.data <= rd_data;
        fault    <= ta_err;
      end
    end
  end

  assign cmd_rdata = {1'b0, fault, 1'b0, ready, cur};

  assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && cmd_wr) |=> $stable(cmd_rdata));

  assert_ready_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ready |-> !busy);
endmodule

// File: rtl/mdio_access_ctrl.sv
module mdio_access_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 start, op_rd, busy, done, ta_err;
  logic                 rise_stb, fall_stb;
  logic [FRAME_LEN-1:0] frame;
  logic [DATA_W-1:0]    rd_data;

  mdio_cmd_reg u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .ta_err(ta_err),
    .start(start), .op_rd(op_rd), .frame(frame), .cmd_rdata(cmd_rdata)
  );

  mdio_clkdiv #(.DIV(MDC_DIV)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .op_rd(op_rd), .frame(frame),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rd_data(rd_data), .ta_err(ta_err)
  );

  // R6: data pin settles only while MDC is low
  assert_mdio_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/sim_mdio_access_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_access_ctrl;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_access_ctrl #(.MDC_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int n_run = 0, n_fail = 0;
  int ncyc = 0;
  int rise_idx = 0;
  int rise_cyc0 = 0, rise_cyc1 = 0;
  logic [63:0] obits, oebits, resp;

  always @(negedge clk) ncyc++;

  // PHY model: observe at MDC rise, answer at MDC fall
  always @(posedge mdc) begin
    if (rise_idx < 64) begin
      obits[63-rise_idx]  = mdio_o;
      oebits[63-rise_idx] = mdio_oe;
    end
    if (rise_idx == 0) rise_cyc0 = ncyc;
    if (rise_idx == 1) rise_cyc1 = ncyc;
    rise_idx++;
  end

  always @(negedge mdc)
    mdio_i = (rise_idx < 64) ? resp[63-rise_idx] : 1'b1;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] d);
    @(negedge clk);
    cmd_wdata = {4'b0, op, phy, rg, d};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4000 && !cmd_rdata[28]; i++) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] d,
                         input logic ta, input logic [15:0] rdv);
    logic rd, ok_op;
    logic [63:0] ef, eoe;
    logic [31:0] er;
    rd    = (op == 2'b10);
    ok_op = (op == 2'b01) || rd;
    resp  = {{47{1'b1}}, ta, rdv};
    rise_idx = 0;
    issue(op, phy, rg, d);
    if (ok_op) begin
      chk(cmd_rdata[31:28] == 4'b0, "R2 flags cleared on accept",
          64'(cmd_rdata[31:28]), 64'h0);
      wait_ready();
      ef  = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
      eoe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
      if (rd) chk(obits[63:18] == ef[63:18], "R5 read header bits",
                  64'(obits[63:18]), 64'(ef[63:18]));
      else    chk(obits == ef, "R5 write frame bits", obits, ef);
      chk(oebits == eoe, "R7 output enable pattern", oebits, eoe);
      chk(rise_idx == 64, "R4 frame length", 64'(rise_idx), 64'd64);
      er = {1'b0, rd & ta, 1'b0, 1'b1, op, phy, rg, rd ? rdv : d};
      chk(cmd_rdata == er, "R1 R6 R8 R9 status readback",
          64'(cmd_rdata), 64'(er));
      chk(mdio_oe == 1'b0 && mdc == 1'b0, "R9 idle pins",
          {62'h0, mdc, mdio_oe}, 64'h0);
    end else begin
      er = {1'b0, 1'b1, 1'b0, 1'b1, op, phy, rg, 16'h0};
      chk(cmd_rdata == er, "R10 illegal op completes with fault",
          64'(cmd_rdata), 64'(er));
      repeat (40) @(negedge clk);
      chk(rise_idx == 0, "R10 no frame sent", 64'(rise_idx), 64'h0);
    end
  endtask

  initial begin
    #(150000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] pend, fin;
    void'($urandom(32'd1357));
    resp = '1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_rdata == 32'h0 && mdc == 1'b0 && mdio_oe == 1'b0,
        "R11 reset state", {30'h0, mdc, mdio_oe, cmd_rdata}, 64'h0);

    run_cmd(2'b01, 5'd1, 5'd0, 16'h1234, 1'b0, 16'h0);
    chk(rise_cyc1 - rise_cyc0 == DIV, "R4 MDC period",
        64'(rise_cyc1 - rise_cyc0), 64'(DIV));
    run_cmd(2'b10, 5'd1, 5'd2, 16'h0, 1'b0, 16'hA5C3);
    run_cmd(2'b10, 5'd1, 5'd3, 16'h0, 1'b1, 16'h5A5A);   // R8 fault
    run_cmd(2'b01, 5'd31, 5'd31, 16'hFFFF, 1'b0, 16'h0);
    run_cmd(2'b10, 5'd0, 5'd0, 16'h0, 1'b0, 16'h0000);
    run_cmd(2'b10, 5'd31, 5'd31, 16'h0, 1'b0, 16'hFFFF);
    run_cmd(2'b00, 5'd4, 5'd9, 16'hBEEF, 1'b0, 16'h0);   // R10
    run_cmd(2'b11, 5'd7, 5'd1, 16'h1111, 1'b0, 16'h0);   // R10

    // R3: second command during a frame is dropped
    resp = '1;
    rise_idx = 0;
    issue(2'b01, 5'd2, 5'd6, 16'h0F0F);
    repeat (100) @(negedge clk);
    pend = {4'b0, 2'b01, 5'd2, 5'd6, 16'h0F0F};
    issue(2'b10, 5'd9, 5'd9, 16'h0);
    chk(cmd_rdata == pend, "R3 status unchanged while busy",
        64'(cmd_rdata), 64'(pend));
    wait_ready();
    fin = pend | 32'h1000_0000;
    chk(cmd_rdata == fin, "R3 first command completes",
        64'(cmd_rdata), 64'(fin));
    repeat (100) @(negedge clk);
    chk(rise_idx == 64 && mdc == 1'b0, "R3 no second frame",
        64'(rise_idx), 64'd64);

    for (int k = 0; k < 24; k++) begin
      logic [1:0] op;
      op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      run_cmd(op, 5'($urandom), 5'($urandom), 16'($urandom),
              ($urandom % 5 == 0), 16'($urandom));
    end
    summary();
  end
endmodule